// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sequences the low-power modes of a small 8-bit microcontroller. Software asks for a mode with single-cycle request strobes. The controller then gates the CPU clock, the peripheral clocks and the oscillator to match that mode. While the core is asleep, it also tells the pad ring which levels to force on the address-latch strobe, the program-store strobe, port 0 and port 2. Those levels depend on whether program memory is on-chip or off-chip.

There are two ways to leave a low-power mode, and they use different wake sources:

- **Idle** ends on any enabled interrupt. A hardware reset also ends it, and that reset opens a short window in which writes to internal RAM are blocked.
- **Power-down** stops the oscillator. It ends only on a hardware reset or on an enabled external interrupt pin that is configured as level-sensitive. Pulling such a pin low restarts the oscillator. The CPU clock stays off for a programmable settle count. Once that count has elapsed, the pin going back high returns the core to run.

A power-on flag is set only by the power-on reset. Software can read and write it, and a warm hardware reset leaves it alone, so software can tell a cold start from a warm one.

States:

| State | Meaning |
|---|---|
| RUN | Normal operation |
| IDLE | CPU clock off, peripherals clocked |
| PDOWN | Oscillator stopped |
| OSC_WAKE | Oscillator restarting, settle count running |
| WAKE_HOLD | Settled, waiting for the wake pin to be released |
| RST_GUARD | Reset-exit window from idle |

Transitions:

| From | To | Condition |
|---|---|---|
| RUN | PDOWN | Power-down request (wins over an idle request in the same cycle) |
| RUN | IDLE | Idle request alone |
| IDLE | RUN | Enabled interrupt |
| IDLE | RST_GUARD | Hardware reset |
| PDOWN | OSC_WAKE | Qualified wake pin low |
| PDOWN | RUN | Hardware reset |
| OSC_WAKE | RUN | Settle count done and no qualified pin low |
| OSC_WAKE | WAKE_HOLD | Settle count done and a qualified pin still low |
| WAKE_HOLD | RUN | Qualified pins released |
| RST_GUARD | RUN | Guard count done |
| OSC_WAKE, WAKE_HOLD | RUN | Hardware reset |

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After the power-on reset (`por_n` low), the block is in RUN.
    - `cpu_clk_en` and `periph_clk_en` are 1.
    - `osc_stop`, `pin_hold`, `ram_wr_inhibit`, `p0_float` and `p2_addr` are 0.
    - `pof` is 1.
    - The settle length is SETTLE_DEF (default 1024).
- R2: In RUN, a `pd_req` strobe enters PDOWN at the next clock edge, also when `idle_req` is high in the same cycle.
- R3: In RUN, an `idle_req` strobe without `pd_req` enters IDLE at the next edge. In IDLE, `cpu_clk_en` is 0, `periph_clk_en` is 1 and `osc_stop` is 0.
- R4: In IDLE, `irq_any` high returns the block to RUN at the next edge.
- R5: In PDOWN, `osc_stop` is 1 and both clock enables are 0.
    - `irq_any` has no effect.
    - An external pin low has no effect unless its bit in both `ext_int_en` and `ext_int_lvl` is 1.
- R6: In PDOWN, a qualified external pin low moves the block to OSC_WAKE, where `osc_stop` is 0.
    - `cpu_clk_en` stays 0 for exactly N cycles, where N is the settle length and a value of 0 counts as 1.
    - RUN follows if no qualified pin is low at that point.
    - Otherwise the block waits in WAKE_HOLD, and moves to RUN at the edge after the pins are released.
- R7: `hw_rst` in RUN, PDOWN, OSC_WAKE or WAKE_HOLD gives RUN at the next edge, and it restores the settle length to SETTLE_DEF.
- R8: `hw_rst` in IDLE enters RST_GUARD.
    - For 2*MC_CLKS cycles, `cpu_clk_en`, `periph_clk_en` and `ram_wr_inhibit` are 1.
    - Then the block is in RUN with `ram_wr_inhibit` 0.
- R9: `pin_hold` is 1 in IDLE, PDOWN, OSC_WAKE and WAKE_HOLD.
    - `ale_lvl` and `psen_lvl` are 1 in IDLE and 0 in the three power-down states.
    - All three outputs are 0 in RUN and RST_GUARD.
- R10: `p0_float` equals `prog_ext` in the four states where `pin_hold` is 1. `p2_addr` equals `prog_ext` in IDLE only. Both are 0 elsewhere.
- R11: `pof` takes `pof_wdata` on a `pof_wr` strobe, holds otherwise, and is not changed by `hw_rst`.
- R12: Request strobes have no effect outside RUN. `hw_rst` has no effect during RST_GUARD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| hw_rst | input | 1 | Synchronous warm hardware reset |
| idle_req | input | 1 | Idle request strobe |
| pd_req | input | 1 | Power-down request strobe |
| irq_any | input | 1 | Any enabled interrupt pending |
| ext_int_n | input | NUM_EXT | External interrupt pins, active low |
| ext_int_en | input | NUM_EXT | Per-pin interrupt enable |
| ext_int_lvl | input | NUM_EXT | Per-pin trigger type, 1 = level-sensitive |
| prog_ext | input | 1 | 1 = program memory is off-chip |
| pof_wr | input | 1 | Power-on flag write strobe |
| pof_wdata | input | 1 | Power-on flag write value |
| settle_wr | input | 1 | Settle length write strobe |
| settle_wdata | input | CNT_W | Settle length write value, in clock cycles |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_stop | output | 1 | Oscillator stop |
| pin_hold | output | 1 | Pads take the forced sleep levels below |
| ale_lvl | output | 1 | Forced address-latch strobe level |
| psen_lvl | output | 1 | Forced program-store strobe level |
| p0_float | output | 1 | Port 0 tri-stated |
| p2_addr | output | 1 | Port 2 drives its address byte |
| ram_wr_inhibit | output | 1 | Internal RAM write block |
| pof | output | 1 | Power-on flag |

## Verification
The bench builds the block with MC_CLKS set to 3, so the idle reset-exit window lasts 6 cycles and its whole span can be watched edge by edge. SETTLE_DEF stays at 1024. One directed wake measures that full default settle after a power-on reset, and a second one measures it after a warm reset, which confirms that the length was restored. Beyond those two runs, software writes settle lengths from 0 to 9. With such short lengths, several thousand random cycles complete many power-down wakes, including held pins, resets during the restart, and the zero-length case.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        PM_RUN       = 3'd0,
        PM_IDLE      = 3'd1,
        PM_PDOWN     = 3'd2,
        PM_OSC_WAKE  = 3'd3,
        PM_WAKE_HOLD = 3'd4,
        PM_RST_GUARD = 3'd5
    } pm_state_e;

endpackage

// File: rtl/pwr_mode_cnt.sv
module pwr_mode_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] remain;

    // Loaded with length-1, so 'done' is seen in the last cycle of the span.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = (remain == '0);

    // A loaded count moves only downward until the next load.
    assert_count_down_R6: assert property (@(posedge clk) disable iff (!por_n)
        (!load && remain != '0) |=> (remain == $past(remain) - 1'b1));

endmodule

// File: rtl/pwr_mode_regs.sv
module pwr_mode_regs #(
    parameter int CNT_W      = 16,
    parameter int SETTLE_DEF = 1024
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             hw_rst,
    input  logic             pof_wr,
    input  logic             pof_wdata,
    input  logic             settle_wr,
    input  logic [CNT_W-1:0] settle_wdata,
    output logic             pof,
    output logic [CNT_W-1:0] settle_len
);

    localparam logic [CNT_W-1:0] SETTLE_RST = CNT_W'(SETTLE_DEF);

    // Power-on flag: only the power-on reset sets it by hardware.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pof <= 1'b1;
        end else if (pof_wr) begin
            pof <= pof_wdata;
        end
    end

    // Settle length behaves as a control register: warm reset restores it.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            settle_len <= SETTLE_RST;
        end else if (hw_rst) begin
            settle_len <= SETTLE_RST;
        end else if (settle_wr) begin
            settle_len <= settle_wdata;
        end
    end

    assert_pof_hold_R11: assert property (@(posedge clk) disable iff (!por_n)
        !pof_wr |=> (pof == $past(pof)));

    assert_settle_warm_R7: assert property (@(posedge clk) disable iff (!por_n)
        hw_rst |=> (settle_len == SETTLE_RST));

endmodule

// File: rtl/pwr_mode_pins.sv
module pwr_mode_pins (
    input  logic in_idle,
    input  logic in_pd,
    input  logic prog_ext,
    output logic pin_hold,
    output logic ale_lvl,
    output logic psen_lvl,
    output logic p0_float,
    output logic p2_addr
);

    // Sleep pad table: strobes high in idle, low in power-down;
    // port 0 floats whenever the bus is off-chip; port 2 keeps its
    // address byte only in idle with off-chip program memory.
    always_comb begin
        pin_hold = in_idle | in_pd;
        ale_lvl  = in_idle;
        psen_lvl = in_idle;
        p0_float = prog_ext & (in_idle | in_pd);
        p2_addr  = prog_ext & in_idle;
    end

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MC_CLKS = 12
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             hw_rst,
    input  logic             idle_req,
    input  logic             pd_req,
    input  logic             irq_any,
    input  logic             wake_pend,
    input  logic             cnt_done,
    input  logic [CNT_W-1:0] settle_len,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             osc_stop,
    output logic             ram_wr_inhibit,
    output logic             in_idle,
    output logic             in_pd
);

    localparam int               GUARD_LEN  = 2 * MC_CLKS;
    localparam logic [CNT_W-1:0] GUARD_LOAD = CNT_W'(GUARD_LEN - 1);

    pm_state_e state, nxt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= PM_RUN;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PM_RUN: begin
                if (hw_rst)        nxt = PM_RUN;
                else if (pd_req)   nxt = PM_PDOWN;
                else if (idle_req) nxt = PM_IDLE;
            end
            PM_IDLE: begin
                if (hw_rst)       nxt = PM_RST_GUARD;
                else if (irq_any) nxt = PM_RUN;
            end
            PM_PDOWN: begin
                if (hw_rst)         nxt = PM_RUN;
                else if (wake_pend) nxt = PM_OSC_WAKE;
            end
            PM_OSC_WAKE: begin
                if (hw_rst)        nxt = PM_RUN;
                else if (cnt_done) nxt = wake_pend ? PM_WAKE_HOLD : PM_RUN;
            end
            PM_WAKE_HOLD: begin
                if (hw_rst || !wake_pend) nxt = PM_RUN;
            end
            PM_RST_GUARD: begin
                if (cnt_done) nxt = PM_RUN;
            end
            default: nxt = PM_RUN;
        endcase
    end

    // One shared counter times both the oscillator settle and the guard.
    always_comb begin
        cnt_load = (nxt != state) &&
                   ((nxt == PM_OSC_WAKE) || (nxt == PM_RST_GUARD));
        if (nxt == PM_OSC_WAKE) begin
            cnt_val = (settle_len == '0) ? '0 : settle_len - 1'b1;
        end else begin
            cnt_val = GUARD_LOAD;
        end
    end

    always_comb begin
        cpu_clk_en     = 1'b0;
        periph_clk_en  = 1'b0;
        osc_stop       = 1'b0;
        ram_wr_inhibit = 1'b0;
        in_idle        = 1'b0;
        in_pd          = 1'b0;
        unique case (state)
            PM_RUN: begin
                cpu_clk_en    = 1'b1;
                periph_clk_en = 1'b1;
            end
            PM_IDLE: begin
                periph_clk_en = 1'b1;
                in_idle       = 1'b1;
            end
            PM_PDOWN: begin
                osc_stop = 1'b1;
                in_pd    = 1'b1;
            end
            PM_OSC_WAKE, PM_WAKE_HOLD: begin
                in_pd = 1'b1;
            end
            PM_RST_GUARD: begin
                cpu_clk_en     = 1'b1;
                periph_clk_en  = 1'b1;
                ram_wr_inhibit = 1'b1;
            end
            default: begin
                cpu_clk_en    = 1'b1;
                periph_clk_en = 1'b1;
            end
        endcase
    end

    assert_pd_priority_R2: assert property (@(posedge clk) disable iff (!por_n)
        (state == PM_RUN && pd_req && !hw_rst) |=> (state == PM_PDOWN));

    assert_idle_entry_R3: assert property (@(posedge clk) disable iff (!por_n)
        (state == PM_RUN && idle_req && !pd_req && !hw_rst) |=> (state == PM_IDLE));

    assert_idle_exit_R4: assert property (@(posedge clk) disable iff (!por_n)
        (state == PM_IDLE && irq_any && !hw_rst) |=> (state == PM_RUN));

    assert_pd_sticky_R5: assert property (@(posedge clk) disable iff (!por_n)
        (state == PM_PDOWN && !wake_pend && !hw_rst) |=> (state == PM_PDOWN));

    assert_wake_gated_R6: assert property (@(posedge clk) disable iff (!por_n)
        (state == PM_OSC_WAKE && !cnt_done && !hw_rst) |=> (state == PM_OSC_WAKE));

    assert_warm_exit_R7: assert property (@(posedge clk) disable iff (!por_n)
        (state == PM_PDOWN && hw_rst) |=> (state == PM_RUN));

    assert_guard_entry_R8: assert property (@(posedge clk) disable iff (!por_n)
        (state == PM_IDLE && hw_rst) |=> (state == PM_RST_GUARD && ram_wr_inhibit));

    assert_guard_holds_R12: assert property (@(posedge clk) disable iff (!por_n)
        (state == PM_RST_GUARD && !cnt_done) |=> (state == PM_RST_GUARD));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
    parameter int NUM_EXT    = 2,
    parameter int CNT_W      = 16,
    parameter int SETTLE_DEF = 1024,
    parameter int MC_CLKS    = 12
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               hw_rst,
    input  logic               idle_req,
    input  logic               pd_req,
    input  logic               irq_any,
    input  logic [NUM_EXT-1:0] ext_int_n,
    input  logic [NUM_EXT-1:0] ext_int_en,
    input  logic [NUM_EXT-1:0] ext_int_lvl,
    input  logic               prog_ext,
    input  logic               pof_wr,
    input  logic               pof_wdata,
    input  logic               settle_wr,
    input  logic [CNT_W-1:0]   settle_wdata,
    output logic               cpu_clk_en,
    output logic               periph_clk_en,
    output logic               osc_stop,
    output logic               pin_hold,
    output logic               ale_lvl,
    output logic               psen_lvl,
    output logic               p0_float,
    output logic               p2_addr,
    output logic               ram_wr_inhibit,
    output logic               pof
);

    logic [NUM_EXT-1:0] wake_bit;
    logic               wake_pend;
    logic               cnt_load, cnt_done;
    logic [CNT_W-1:0]   cnt_val, settle_len;
    logic               in_idle, in_pd;

    // Only enabled, level-configured pins held low may wake from power-down.
    for (genvar g = 0; g < NUM_EXT; g++) begin : g_wake
        assign wake_bit[g] = ext_int_en[g] & ext_int_lvl[g] & ~ext_int_n[g];
    end
    assign wake_pend = |wake_bit;

    pwr_mode_regs #(
        .CNT_W      (CNT_W),
        .SETTLE_DEF (SETTLE_DEF)
    ) u_regs (
        .clk          (clk),
        .por_n        (por_n),
        .hw_rst       (hw_rst),
        .pof_wr       (pof_wr),
        .pof_wdata    (pof_wdata),
        .settle_wr    (settle_wr),
        .settle_wdata (settle_wdata),
        .pof          (pof),
        .settle_len   (settle_len)
    );

    pwr_mode_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .por_n    (por_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    pwr_mode_fsm #(
        .CNT_W   (CNT_W),
        .MC_CLKS (MC_CLKS)
    ) u_fsm (
        .clk            (clk),
        .por_n          (por_n),
        .hw_rst         (hw_rst),
        .idle_req       (idle_req),
        .pd_req         (pd_req),
        .irq_any        (irq_any),
        .wake_pend      (wake_pend),
        .cnt_done       (cnt_done),
        .settle_len     (settle_len),
        .cnt_load       (cnt_load),
        .cnt_val        (cnt_val),
        .cpu_clk_en     (cpu_clk_en),
        .periph_clk_en  (periph_clk_en),
        .osc_stop       (osc_stop),
        .ram_wr_inhibit (ram_wr_inhibit),
        .in_idle        (in_idle),
        .in_pd          (in_pd)
    );

    pwr_mode_pins u_pins (
        .in_idle  (in_idle),
        .in_pd    (in_pd),
        .prog_ext (prog_ext),
        .pin_hold (pin_hold),
        .ale_lvl  (ale_lvl),
        .psen_lvl (psen_lvl),
        .p0_float (p0_float),
        .p2_addr  (p2_addr)
    );

    assert_cpu_off_pd_R5: assert property (@(posedge clk) disable iff (!por_n)
        osc_stop |-> (!cpu_clk_en && !periph_clk_en && pin_hold && !ale_lvl));

    assert_pads_sleep_R9: assert property (@(posedge clk) disable iff (!por_n)
        cpu_clk_en |-> (!pin_hold && !p0_float && !p2_addr));

    assert_p2_idle_R10: assert property (@(posedge clk) disable iff (!por_n)
        p2_addr |-> (periph_clk_en && !cpu_clk_en && prog_ext));

endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;

    localparam int NE  = 2;
    localparam int CW  = 16;
    localparam int DEF = 1024;
    localparam int MC  = 3;
    localparam int GL  = 2 * MC;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          hw_rst = 1'b0, idle_req = 1'b0, pd_req = 1'b0, irq_any = 1'b0;
    logic [NE-1:0] ext_int_n = '1, ext_int_en = '0, ext_int_lvl = '0;
    logic          prog_ext = 1'b0, pof_wr = 1'b0, pof_wdata = 1'b0, settle_wr = 1'b0;
    logic [CW-1:0] settle_wdata = '0;
    logic cpu_clk_en, periph_clk_en, osc_stop, pin_hold, ale_lvl, psen_lvl;
    logic p0_float, p2_addr, ram_wr_inhibit, pof;

    always #2 clk = ~clk;

    pwr_mode_ctrl #(.NUM_EXT(NE), .CNT_W(CW), .SETTLE_DEF(DEF), .MC_CLKS(MC)) uut (
        .clk(clk), .por_n(por_n), .hw_rst(hw_rst), .idle_req(idle_req),
        .pd_req(pd_req), .irq_any(irq_any), .ext_int_n(ext_int_n),
        .ext_int_en(ext_int_en), .ext_int_lvl(ext_int_lvl), .prog_ext(prog_ext),
        .pof_wr(pof_wr), .pof_wdata(pof_wdata), .settle_wr(settle_wr),
        .settle_wdata(settle_wdata), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .osc_stop(osc_stop), .pin_hold(pin_hold),
        .ale_lvl(ale_lvl), .psen_lvl(psen_lvl), .p0_float(p0_float),
        .p2_addr(p2_addr), .ram_wr_inhibit(ram_wr_inhibit), .pof(pof)
    );

    int errs = 0;
    int checks = 0;
    bit finished = 0;

    // Reference model: 0 RUN, 1 IDLE, 2 PDOWN, 3 OSC_WAKE, 4 WAKE_HOLD, 5 RST_GUARD
    int m_st = 0;
    int m_left = 0;
    int m_settle = DEF;
    bit m_pof = 1;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit wake_q();
        return |(ext_int_en & ext_int_lvl & ~ext_int_n);
    endfunction

    task automatic model_reset();
        m_st = 0; m_left = 0; m_settle = DEF; m_pof = 1;
    endtask

    task automatic model_edge();
        int ns = m_st;
        bit w = wake_q();
        case (m_st)
            0: if (hw_rst) ns = 0; else if (pd_req) ns = 2; else if (idle_req) ns = 1;
            1: if (hw_rst) begin ns = 5; m_left = GL; end else if (irq_any) ns = 0;
            2: if (hw_rst) ns = 0;
               else if (w) begin ns = 3; m_left = (m_settle == 0) ? 1 : m_settle; end
            3: if (hw_rst) ns = 0;
               else if (m_left == 1) ns = w ? 4 : 0;
               else m_left--;
            4: if (hw_rst || !w) ns = 0;
            5: if (m_left == 1) ns = 0; else m_left--;
            default: ns = 0;
        endcase
        m_st = ns;
        if (pof_wr) m_pof = pof_wdata;
        if (hw_rst) m_settle = DEF;
        else if (settle_wr) m_settle = int'(settle_wdata);
    endtask

    task automatic cmp();
        bit slp = (m_st >= 1 && m_st <= 4);
        bit e_cpu = (m_st == 0 || m_st == 5);
        bit e_per = (m_st == 0 || m_st == 1 || m_st == 5);
        chk(cpu_clk_en == e_cpu, "R6", "cpu_clk_en", cpu_clk_en, e_cpu);
        chk(periph_clk_en == e_per, "R3", "periph_clk_en", periph_clk_en, e_per);
        chk(osc_stop == (m_st == 2), "R5", "osc_stop", osc_stop, m_st == 2);
        chk(pin_hold == slp, "R9", "pin_hold", pin_hold, slp);
        chk(ale_lvl == (m_st == 1) && psen_lvl == (m_st == 1), "R9", "ale/psen",
            {ale_lvl, psen_lvl}, {2{m_st == 1}});
        chk(p0_float == (prog_ext & slp), "R10", "p0_float", p0_float, prog_ext & slp);
        chk(p2_addr == (prog_ext & (m_st == 1)), "R10", "p2_addr", p2_addr,
            prog_ext & (m_st == 1));
        chk(ram_wr_inhibit == (m_st == 5), "R8", "ram_wr_inhibit", ram_wr_inhibit, m_st == 5);
        chk(pof == m_pof, "R11", "pof", pof, m_pof);
    endtask

    task automatic clr();
        hw_rst = 0; idle_req = 0; pd_req = 0; irq_any = 0;
        pof_wr = 0; settle_wr = 0;
    endtask

    // Inputs were set before the call (at a negedge); sample after the edge.
    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        cmp();
        @(negedge clk);
        clr();
    endtask

    task automatic idle_steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_por();
        @(negedge clk);
        clr();
        por_n = 0;
        model_reset();
        #1;
        cmp();
        @(negedge clk);
        por_n = 1;
    endtask

    task automatic set_settle(int v);
        settle_wr = 1; settle_wdata = CW'(v); step();
    endtask

    initial begin
        int k;
        void'($urandom(32'd5271));
        repeat (3) @(negedge clk);
        por_n = 1;
        #1;
        // R1: reset state
        chk(cpu_clk_en && periph_clk_en && !osc_stop && !pin_hold && !ram_wr_inhibit,
            "R1", "reset clocks", {cpu_clk_en, periph_clk_en, osc_stop}, 3'b110);
        chk(pof == 1'b1, "R1", "reset pof", pof, 1);
        @(negedge clk);

        // R1/R6: default settle length is measured in full
        pd_req = 1; step();
        chk(osc_stop == 1'b1, "R2", "pd entry", osc_stop, 1);
        ext_int_en = 2'b01; ext_int_lvl = 2'b01; ext_int_n = 2'b10; step();
        chk(osc_stop == 1'b0 && cpu_clk_en == 1'b0, "R6", "osc restart",
            {osc_stop, cpu_clk_en}, 0);
        ext_int_n = 2'b11;
        k = 0;
        while (!cpu_clk_en && k < 5000) begin step(); k++; end
        chk(k == DEF, "R1", "default settle cycles", k, DEF);

        // R2: both requests at once resolve to power-down
        set_settle(3);
        idle_req = 1; pd_req = 1; step();
        chk(osc_stop && !periph_clk_en, "R2", "pd wins", osc_stop, 1);

        // R5: irq, edge-configured and disabled pins do not wake
        irq_any = 1; ext_int_en = 2'b11; ext_int_lvl = 2'b01; ext_int_n = 2'b01; step();
        ext_int_en = 2'b10; ext_int_lvl = 2'b11; ext_int_n = 2'b10; step();
        chk(osc_stop == 1'b1, "R5", "no wake", osc_stop, 1);
        // R12: requests ignored outside RUN
        idle_req = 1; step();
        chk(osc_stop == 1'b1 && ale_lvl == 1'b0, "R12", "req in pd", osc_stop, 1);

        // R6: wake held low past settle goes to hold
        ext_int_n = 2'b00; step();
        idle_steps(3 + 4);
        chk(cpu_clk_en == 1'b0 && osc_stop == 1'b0, "R6", "hold while low", cpu_clk_en, 0);
        ext_int_n = 2'b11; step();
        chk(cpu_clk_en == 1'b1, "R6", "release to run", cpu_clk_en, 1);

        // R6: zero settle behaves as one cycle
        set_settle(0);
        pd_req = 1; step();
        ext_int_n = 2'b01; step();
        ext_int_n = 2'b11; step();
        chk(cpu_clk_en == 1'b1, "R6", "zero settle", cpu_clk_en, 1);

        // R7/R11: warm reset in power-down; pof kept
        pof_wr = 1; pof_wdata = 0; step();
        chk(pof == 1'b0, "R11", "pof write", pof, 0);
        pd_req = 1; step();
        hw_rst = 1; step();
        chk(cpu_clk_en == 1'b1 && pof == 1'b0, "R7", "warm exit", {cpu_clk_en, pof}, 2'b10);

        // R3/R9/R10: idle with off-chip program memory
        prog_ext = 1; idle_req = 1; step();
        chk(!cpu_clk_en && periph_clk_en && ale_lvl && psen_lvl && p0_float && p2_addr,
            "R3", "idle ext", {ale_lvl, p0_float, p2_addr}, 3'b111);
        // R12: power-down request in idle ignored
        pd_req = 1; step();
        chk(osc_stop == 1'b0 && periph_clk_en == 1'b1, "R12", "pd in idle", osc_stop, 0);
        // R8: reset from idle opens the guard window
        hw_rst = 1; step();
        for (int i = 1; i < GL; i++) begin
            chk(ram_wr_inhibit == 1'b1, "R8", "guard on", ram_wr_inhibit, 1);
            hw_rst = 1; pd_req = 1; step();
        end
        chk(ram_wr_inhibit == 1'b1 && cpu_clk_en, "R8", "guard last", ram_wr_inhibit, 1);
        step();
        chk(ram_wr_inhibit == 1'b0 && cpu_clk_en, "R8", "guard end", ram_wr_inhibit, 0);

        // R4/R10: idle with on-chip memory, exit on interrupt
        prog_ext = 0; idle_req = 1; step();
        chk(p0_float == 1'b0 && p2_addr == 1'b0, "R10", "idle int", {p0_float, p2_addr}, 0);
        irq_any = 1; step();
        chk(cpu_clk_en == 1'b1, "R4", "idle irq exit", cpu_clk_en, 1);

        // R9/R10: power-down with off-chip memory
        prog_ext = 1; pd_req = 1; step();
        chk(p0_float && !p2_addr && pin_hold && !ale_lvl && !psen_lvl, "R10", "pd ext",
            {p0_float, p2_addr, ale_lvl}, 3'b100);
        hw_rst = 1; step();

        // R7: warm reset restored the settle length to its default
        set_settle(2);
        hw_rst = 1; step();
        pd_req = 1; step();
        ext_int_n = 2'b10; ext_int_en = 2'b01; ext_int_lvl = 2'b01; step();
        ext_int_n = 2'b11;
        k = 0;
        while (!cpu_clk_en && k < 5000) begin step(); k++; end
        chk(k == DEF, "R7", "settle restored", k, DEF);

        // R11/R1: power-on reset sets the flag again
        pof_wr = 1; pof_wdata = 0; step();
        do_por();
        chk(pof == 1'b1, "R11", "pof after por", pof, 1);

        // Constrained random phase
        for (int n = 0; n < 5000; n++) begin
            hw_rst    = ($urandom_range(59) == 0);
            idle_req  = ($urandom_range(9) == 0);
            pd_req    = ($urandom_range(11) == 0);
            irq_any   = ($urandom_range(5) == 0);
            prog_ext  = ($urandom_range(1) == 1);
            for (int b = 0; b < NE; b++) begin
                ext_int_n[b]   = ($urandom_range(4) != 0);
                ext_int_en[b]  = ($urandom_range(3) != 0);
                ext_int_lvl[b] = ($urandom_range(3) != 0);
            end
            pof_wr    = ($urandom_range(24) == 0);
            pof_wdata = ($urandom_range(1) == 1);
            settle_wr = ($urandom_range(29) == 0);
            settle_wdata = CW'($urandom_range(9));
            step();
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errs++;
            $display("FAIL watchdog run did not complete");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule